// File: doc/BRIEF.md
# Multi-Channel Match-Compare Timer

This peripheral holds several independent up-counters that tick on a timer clock separate from the register bus clock. Each counter has a set of match comparators. When the count equals a comparator's match value while the counter runs, that comparator's sticky status bit is set. Each counter has one interrupt output, which is active while any of its status bits has its enable bit set. A counter is either free-running, wrapping through its full range, or periodic, returning to zero on the tick after it equals the value of comparator 0.

Software controls the block through a flat word-addressed register file. The running count is never read directly across the clock boundary. Software writes a capture request and polls a busy bit. It then reads a snapshot that the timer domain took and handed back through a toggle handshake. Run bits, comparator events and capture requests cross the clock boundary through two-flop synchronizers. Mode and match values are quasi-static: software programs them while the counter is stopped. The timer clock must run at no more than half the bus clock rate.

Addresses are word indices. Address 0 is the run register, 1 the clock-select register and 2 the capture-busy register. Timer t owns the block at 8+8t: mode at +0, interrupt enable at +1, status/clear at +2, capture at +3, and the match value of comparator k at +4+k.

Top module: `mct_top`

## Requirements
- R1: Bit t of the run register (address 0) runs timer t. Writing 0 stops every counter. A stopped counter holds count 0, so it restarts from 0 when it runs again.
- R2: In free-running mode (mode bit 0 = 0), a running counter advances by one per timer clock and wraps from 2^CNT_W-1 to 0.
- R3: In periodic mode (mode bit 0 = 1), the count goes to 0 on the tick after it equals comparator 0's match value, so a captured count never exceeds that value and the matches recur.
- R4: With match value N-1, status bit k (timer status register, bit k = comparator k) sets after N running ticks and stays set until cleared.
- R5: Writing the status register clears exactly the bits written as 1. Bits written as 0 are left unchanged.
- R6: irq_o[t] is high exactly when some status bit of timer t has its interrupt-enable bit (enable register bit k = comparator k) set.
- R7: Writing the capture register with bit 0 = 1 sets bit t of the busy register (address 2) on the next bus cycle. Busy clears once the snapshot is readable at the capture address. A write with bit 0 = 0, or a write while busy, is ignored.
- R8: The clock-select register holds a 2-bit field per timer at bits [2t+1:2t]. It reads back as written, drives clk_sel_o, and resets to 0.
- R9: Timers are independent: a match on one timer changes no other timer's status or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| tmr_clk | input | 1 | Counter tick clock |
| tmr_rst_n | input | 1 | Asynchronous active-low reset, timer domain |
| wr_en | input | 1 | Write strobe for one bus cycle |
| addr | input | AW | Word address for read and write |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for addr, combinational |
| irq_o | output | NT | One interrupt per timer |
| clk_sel_o | output | NT*SEL_W | Clock-select fields for an external prescaler |

## Verification
Several properties are checked on every clock edge. On the timer side, the checker holds a stopped counter at zero, checks the one-per-tick step, and checks the reload in periodic mode. On the bus side, it checks that a status bit falls only after a clear write naming it, that busy rises after an accepted capture request, and that no interrupt is raised without an enable. The match latency window, the wrap-around, the snapshot values and the independence between timers involve delays across the clock boundary. Only the bench's scenarios can show these, by sweeping every timer, comparator and several match values and checking bounded latency windows.

// File: rtl/mct_pkg.sv
package mct_pkg;
    localparam int unsigned REG_RUN     = 0;
    localparam int unsigned REG_CLKSEL  = 1;
    localparam int unsigned REG_BUSY    = 2;
    localparam int unsigned TBLK_BASE   = 8;
    localparam int unsigned TBLK_STRIDE = 8;
    localparam int unsigned TOFF_MODE   = 0;
    localparam int unsigned TOFF_IE     = 1;
    localparam int unsigned TOFF_STAT   = 2;
    localparam int unsigned TOFF_CAP    = 3;
    localparam int unsigned TOFF_MATCH  = 4;

    typedef enum logic {
        MODE_FREE     = 1'b0,
        MODE_PERIODIC = 1'b1
    } mode_e;

    function automatic int unsigned tmr_addr(int unsigned t, int unsigned off);
        return TBLK_BASE + t * TBLK_STRIDE + off;
    endfunction
endpackage

// File: rtl/mct_sync.sv
module mct_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mct_counter.sv
module mct_counter
    import mct_pkg::*;
#(
    parameter int NC    = 3,
    parameter int CNT_W = 32
) (
    input  logic                       tclk,
    input  logic                       trst_n,
    input  logic                       run_a,
    input  logic                       req_tgl_a,
    input  logic                       periodic_i,
    input  logic [NC-1:0][CNT_W-1:0]   match_i,
    output logic [NC-1:0]              evt_tgl_o,
    output logic [CNT_W-1:0]           snap_o,
    output logic                       ack_tgl_o,
    output logic [CNT_W-1:0]           cnt_o,
    output logic                       run_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] snap;
        logic [NC-1:0]    evt_tgl;
        logic             ack_tgl;
        logic             req_last;
    } cstate_t;

    cstate_t     s_d, s_q;
    logic        run_s, req_s;
    logic [NC-1:0] hit;

    mct_sync #(.W(2), .STAGES(2)) u_sync (
        .clk   (tclk),
        .rst_n (trst_n),
        .d_i   ({req_tgl_a, run_a}),
        .q_o   ({req_s, run_s})
    );

    for (genvar k = 0; k < NC; k++) begin : g_cmp
        assign hit[k] = run_s && (s_q.cnt == match_i[k]);
    end

    always_comb begin
        s_d = s_q;
        if (!run_s) begin
            s_d.cnt = '0;
        end else if ((periodic_i == MODE_PERIODIC) && hit[0]) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
        s_d.evt_tgl = s_q.evt_tgl ^ hit;
        if (req_s != s_q.req_last) begin
            s_d.snap     = s_q.cnt;
            s_d.ack_tgl  = ~s_q.ack_tgl;
            s_d.req_last = req_s;
        end
    end

    always_ff @(posedge tclk or negedge trst_n) begin
        if (!trst_n) s_q <= '0;
        else         s_q <= s_d;
    end

    assign evt_tgl_o = s_q.evt_tgl;
    assign snap_o    = s_q.snap;
    assign ack_tgl_o = s_q.ack_tgl;
    assign cnt_o     = s_q.cnt;
    assign run_o     = run_s;
endmodule

// File: rtl/mct_regs.sv
module mct_regs
    import mct_pkg::*;
#(
    parameter int NT    = 3,
    parameter int NC    = 3,
    parameter int CNT_W = 32,
    parameter int AW    = 6,
    parameter int DW    = 32,
    parameter int SEL_W = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [AW-1:0]                     addr,
    input  logic [DW-1:0]                     wdata,
    output logic [DW-1:0]                     rdata,
    input  logic [NT-1:0][NC-1:0]             evt_tgl_a,
    input  logic [NT-1:0]                     ack_tgl_a,
    input  logic [NT-1:0][CNT_W-1:0]          snap_a,
    output logic [NT-1:0]                     run_o,
    output logic [NT-1:0]                     periodic_o,
    output logic [NT-1:0][NC-1:0][CNT_W-1:0]  match_o,
    output logic [NT-1:0]                     req_tgl_o,
    output logic [NT*SEL_W-1:0]               clk_sel_o,
    output logic [NT-1:0]                     irq_o,
    output logic [NT-1:0][NC-1:0]             status_o,
    output logic [NT-1:0][NC-1:0]             ie_o,
    output logic [NT-1:0]                     busy_o
);
    localparam int EVW = NT * NC;

    typedef struct packed {
        logic [NT-1:0]                    run;
        logic [NT*SEL_W-1:0]              clksel;
        logic [NT-1:0]                    periodic;
        logic [NT-1:0][NC-1:0]            ie;
        logic [NT-1:0][NC-1:0]            status;
        logic [NT-1:0][NC-1:0][CNT_W-1:0] match;
        logic [NT-1:0]                    req_tgl;
        logic [NT-1:0]                    busy;
        logic [NT-1:0][CNT_W-1:0]         cap;
        logic [NT-1:0][NC-1:0]            evt_last;
        logic [NT-1:0]                    ack_last;
    } rstate_t;

    rstate_t                s_d, s_q;
    logic [EVW+NT-1:0]      sync_q;
    logic [NT-1:0][NC-1:0]  evt_s, evt_hit, clr;
    logic [NT-1:0]          ack_s, ack_hit;

    mct_sync #(.W(EVW + NT), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ack_tgl_a, evt_tgl_a}),
        .q_o   (sync_q)
    );

    assign evt_s = sync_q[EVW-1:0];
    assign ack_s = sync_q[EVW+NT-1:EVW];

    always_comb begin
        s_d          = s_q;
        clr          = '0;
        evt_hit      = evt_s ^ s_q.evt_last;
        ack_hit      = ack_s ^ s_q.ack_last;
        s_d.evt_last = evt_s;
        s_d.ack_last = ack_s;

        for (int t = 0; t < NT; t++) begin
            if (ack_hit[t]) begin
                s_d.cap[t]  = snap_a[t];
                s_d.busy[t] = 1'b0;
            end
        end

        if (wr_en) begin
            if (addr == AW'(REG_RUN))    s_d.run    = wdata[NT-1:0];
            if (addr == AW'(REG_CLKSEL)) s_d.clksel = wdata[NT*SEL_W-1:0];
            for (int t = 0; t < NT; t++) begin
                if (addr == AW'(tmr_addr(t, TOFF_MODE))) s_d.periodic[t] = wdata[0];
                if (addr == AW'(tmr_addr(t, TOFF_IE)))   s_d.ie[t]       = wdata[NC-1:0];
                if (addr == AW'(tmr_addr(t, TOFF_STAT))) clr[t]          = wdata[NC-1:0];
                if (addr == AW'(tmr_addr(t, TOFF_CAP)) && wdata[0] && !s_q.busy[t]) begin
                    s_d.req_tgl[t] = ~s_q.req_tgl[t];
                    s_d.busy[t]    = 1'b1;
                end
                for (int k = 0; k < NC; k++) begin
                    if (addr == AW'(tmr_addr(t, TOFF_MATCH + k))) s_d.match[t][k] = wdata[CNT_W-1:0];
                end
            end
        end

        // a new event wins over a clear landing in the same cycle
        s_d.status = (s_q.status & ~clr) | evt_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(REG_RUN))    rdata = DW'(s_q.run);
        if (addr == AW'(REG_CLKSEL)) rdata = DW'(s_q.clksel);
        if (addr == AW'(REG_BUSY))   rdata = DW'(s_q.busy);
        for (int t = 0; t < NT; t++) begin
            if (addr == AW'(tmr_addr(t, TOFF_MODE))) rdata = DW'(s_q.periodic[t]);
            if (addr == AW'(tmr_addr(t, TOFF_IE)))   rdata = DW'(s_q.ie[t]);
            if (addr == AW'(tmr_addr(t, TOFF_STAT))) rdata = DW'(s_q.status[t]);
            if (addr == AW'(tmr_addr(t, TOFF_CAP)))  rdata = DW'(s_q.cap[t]);
            for (int k = 0; k < NC; k++) begin
                if (addr == AW'(tmr_addr(t, TOFF_MATCH + k))) rdata = DW'(s_q.match[t][k]);
            end
        end
    end

    for (genvar t = 0; t < NT; t++) begin : g_irq
        assign irq_o[t] = |(s_q.status[t] & s_q.ie[t]);
    end

    assign run_o      = s_q.run;
    assign periodic_o = s_q.periodic;
    assign match_o    = s_q.match;
    assign req_tgl_o  = s_q.req_tgl;
    assign clk_sel_o  = s_q.clksel;
    assign status_o   = s_q.status;
    assign ie_o       = s_q.ie;
    assign busy_o     = s_q.busy;
endmodule

// File: rtl/mct_top.sv
module mct_top
    import mct_pkg::*;
#(
    parameter int NT    = 3,
    parameter int NC    = 3,
    parameter int CNT_W = 32,
    parameter int AW    = 6,
    parameter int DW    = 32,
    parameter int SEL_W = 2
) (
    input  logic                 bus_clk,
    input  logic                 bus_rst_n,
    input  logic                 tmr_clk,
    input  logic                 tmr_rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    output logic [NT-1:0]        irq_o,
    output logic [NT*SEL_W-1:0]  clk_sel_o
);
    logic [NT-1:0]                    run_w, periodic_w, req_tgl_w, ack_tgl_w, busy_w, run_s_w;
    logic [NT-1:0][NC-1:0][CNT_W-1:0] match_w;
    logic [NT-1:0][NC-1:0]            evt_tgl_w, status_w, ie_w;
    logic [NT-1:0][CNT_W-1:0]         snap_w, cnt_w;

    mct_regs #(
        .NT(NT), .NC(NC), .CNT_W(CNT_W), .AW(AW), .DW(DW), .SEL_W(SEL_W)
    ) u_regs (
        .clk        (bus_clk),
        .rst_n      (bus_rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .evt_tgl_a  (evt_tgl_w),
        .ack_tgl_a  (ack_tgl_w),
        .snap_a     (snap_w),
        .run_o      (run_w),
        .periodic_o (periodic_w),
        .match_o    (match_w),
        .req_tgl_o  (req_tgl_w),
        .clk_sel_o  (clk_sel_o),
        .irq_o      (irq_o),
        .status_o   (status_w),
        .ie_o       (ie_w),
        .busy_o     (busy_w)
    );

    for (genvar t = 0; t < NT; t++) begin : g_tmr
        mct_counter #(.NC(NC), .CNT_W(CNT_W)) u_cnt (
            .tclk       (tmr_clk),
            .trst_n     (tmr_rst_n),
            .run_a      (run_w[t]),
            .req_tgl_a  (req_tgl_w[t]),
            .periodic_i (periodic_w[t]),
            .match_i    (match_w[t]),
            .evt_tgl_o  (evt_tgl_w[t]),
            .snap_o     (snap_w[t]),
            .ack_tgl_o  (ack_tgl_w[t]),
            .cnt_o      (cnt_w[t]),
            .run_o      (run_s_w[t])
        );
    end
endmodule

// File: rtl/mct_checker.sv
module mct_checker
    import mct_pkg::*;
#(
    parameter int NT    = 3,
    parameter int NC    = 3,
    parameter int CNT_W = 32,
    parameter int AW    = 6,
    parameter int DW    = 32
) (
    input logic                             bus_clk,
    input logic                             bus_rst_n,
    input logic                             tmr_clk,
    input logic                             tmr_rst_n,
    input logic                             wr_en,
    input logic [AW-1:0]                    addr,
    input logic [DW-1:0]                    wdata,
    input logic [NT-1:0]                    irq_o,
    input logic [NT-1:0][NC-1:0]            status_w,
    input logic [NT-1:0][NC-1:0]            ie_w,
    input logic [NT-1:0]                    busy_w,
    input logic [NT-1:0][CNT_W-1:0]         cnt_w,
    input logic [NT-1:0]                    run_s_w,
    input logic [NT-1:0]                    periodic_w,
    input logic [NT-1:0][NC-1:0][CNT_W-1:0] match_w
);
    for (genvar t = 0; t < NT; t++) begin : g_t
        assert_stop_zero_R1: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
            !run_s_w[t] |=> (cnt_w[t] == '0));

        assert_step_one_R2: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
            (run_s_w[t] && !(periodic_w[t] && (cnt_w[t] == match_w[t][0])))
            |=> (cnt_w[t] == $past(cnt_w[t]) + CNT_W'(1)));

        assert_periodic_reload_R3: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
            (run_s_w[t] && periodic_w[t] && (cnt_w[t] == match_w[t][0])) |=> (cnt_w[t] == '0));

        assert_irq_needs_enable_R6: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
            irq_o[t] |-> (ie_w[t] != '0));

        assert_busy_set_R7: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
            (wr_en && (addr == AW'(tmr_addr(t, TOFF_CAP))) && wdata[0] && !busy_w[t]) |=> busy_w[t]);

        for (genvar k = 0; k < NC; k++) begin : g_k
            // R4 sticky, R5 only a clear write naming the bit drops it
            assert_status_sticky_R5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
                $fell(status_w[t][k]) |->
                    $past(wr_en && (addr == AW'(tmr_addr(t, TOFF_STAT))) && wdata[k]));
        end
    end
endmodule

bind mct_top mct_checker #(
    .NT(NT), .NC(NC), .CNT_W(CNT_W), .AW(AW), .DW(DW)
) u_chk (
    .bus_clk    (bus_clk),
    .bus_rst_n  (bus_rst_n),
    .tmr_clk    (tmr_clk),
    .tmr_rst_n  (tmr_rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .irq_o      (irq_o),
    .status_w   (status_w),
    .ie_w       (ie_w),
    .busy_w     (busy_w),
    .cnt_w      (cnt_w),
    .run_s_w    (run_s_w),
    .periodic_w (periodic_w),
    .match_w    (match_w)
);

// File: tb/mct_top_test.sv
module mct_top_test;
    import mct_pkg::*;

    localparam int NT = 3, NC = 3, CW = 8, AW = 6, DW = 32, SW = 2;

    logic bclk = 1'b0, tclk = 1'b0, brst_n = 1'b0, trst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [NT-1:0] irq;
    logic [NT*SW-1:0] clk_sel;

    int total = 0, bad = 0;

    always #2 bclk = ~bclk;  // 250 MHz bus clock
    always #4 tclk = ~tclk;  // timer clock at half rate

    mct_top #(.NT(NT), .NC(NC), .CNT_W(CW), .AW(AW), .DW(DW), .SEL_W(SW)) uut (
        .bus_clk(bclk), .bus_rst_n(brst_n), .tmr_clk(tclk), .tmr_rst_n(trst_n),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_o(irq), .clk_sel_o(clk_sel)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge bclk);
        wr_en = 1'b1; addr = AW'(a); wdata = DW'(d);
        @(posedge bclk);
        @(negedge bclk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        addr = AW'(a);
        #1;
        d = int'(rdata);
    endtask

    task automatic capture(input int t, output int v);
        int b;
        wr(tmr_addr(t, TOFF_CAP), 1);
        rd(REG_BUSY, b);
        chk(b[t] == 1'b1, "R7 busy after request", b[t], 1);
        for (int i = 0; i < 40; i++) begin
            rd(REG_BUSY, b);
            if (b[t] == 1'b0) break;
            @(negedge bclk);
        end
        chk(b[t] == 1'b0, "R7 busy clears", b[t], 0);
        rd(tmr_addr(t, TOFF_CAP), v);
    endtask

    task automatic quiesce();
        wr(REG_RUN, 0);
        repeat (20) @(negedge bclk);
        for (int u = 0; u < NT; u++) begin
            wr(tmr_addr(u, TOFF_IE), 0);
            wr(tmr_addr(u, TOFF_STAT), 7);
            wr(tmr_addr(u, TOFF_MODE), 0);
            for (int k = 0; k < NC; k++) wr(tmr_addr(u, TOFF_MATCH + k), 255);
        end
    endtask

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v, prev, mx;
        bit wrapped;
        repeat (5) @(negedge bclk);
        brst_n = 1'b1; trst_n = 1'b1;
        repeat (3) @(negedge bclk);

        // reset state
        rd(REG_RUN, v);    chk(v == 0, "R1 run resets to 0", v, 0);
        rd(REG_BUSY, v);   chk(v == 0, "R7 busy resets to 0", v, 0);
        rd(REG_CLKSEL, v); chk(v == 0, "R8 clock select resets to 0", v, 0);
        chk(clk_sel == 0, "R8 clk_sel_o reset", int'(clk_sel), 0);
        chk(irq == 0, "R6 irq reset", int'(irq), 0);

        // R4 R6 R9: sweep over timer, comparator and match value
        for (int t = 0; t < NT; t++) begin
            for (int k = 0; k < NC; k++) begin
                for (int ni = 0; ni < 3; ni++) begin
                    int n;
                    n = (ni == 0) ? 1 : (ni == 1) ? 2 : 5;
                    quiesce();
                    wr(tmr_addr(t, TOFF_MATCH + k), n - 1);
                    wr(tmr_addr(t, TOFF_IE), 1 << k);
                    wr(REG_RUN, 1 << t);
                    repeat (2 * n + 4) @(negedge bclk);
                    rd(tmr_addr(t, TOFF_STAT), v);
                    chk(v == 0, "R4 status not before N ticks", v, 0);
                    repeat (6) @(negedge bclk);
                    rd(tmr_addr(t, TOFF_STAT), v);
                    chk(v == (1 << k), "R4 status after N ticks", v, 1 << k);
                    chk(irq == NT'(1 << t), "R9 R6 only own irq", int'(irq), 1 << t);
                    repeat (20) @(negedge bclk);
                    rd(tmr_addr(t, TOFF_STAT), v);
                    chk(v[k] == 1'b1, "R4 status sticky", v[k], 1);
                end
            end
        end

        // R5 and R6 on timer 0
        quiesce();
        for (int k = 0; k < NC; k++) wr(tmr_addr(0, TOFF_MATCH + k), k + 1);
        wr(REG_RUN, 1);
        repeat (30) @(negedge bclk);
        wr(REG_RUN, 0);
        repeat (20) @(negedge bclk);
        rd(tmr_addr(0, TOFF_STAT), v); chk(v == 7, "R4 all comparators set", v, 7);
        chk(irq[0] == 1'b0, "R6 masked status gives no irq", irq[0], 0);
        wr(tmr_addr(0, TOFF_IE), 4);
        chk(irq[0] == 1'b1, "R6 enabled status raises irq", irq[0], 1);
        wr(tmr_addr(0, TOFF_STAT), 2);
        rd(tmr_addr(0, TOFF_STAT), v); chk(v == 5, "R5 clear only bit 1", v, 5);
        wr(tmr_addr(0, TOFF_STAT), 0);
        rd(tmr_addr(0, TOFF_STAT), v); chk(v == 5, "R5 zero write no effect", v, 5);
        wr(tmr_addr(0, TOFF_STAT), 4);
        chk(irq[0] == 1'b0, "R6 irq drops after clear", irq[0], 0);
        wr(tmr_addr(0, TOFF_STAT), 1);
        rd(tmr_addr(0, TOFF_STAT), v); chk(v == 0, "R5 all cleared", v, 0);

        // R7: capture of stopped counter, ignored request
        capture(0, v); chk(v == 0, "R1 stopped count is 0", v, 0);
        wr(tmr_addr(0, TOFF_CAP), 2);
        rd(REG_BUSY, v); chk(v == 0, "R7 write with bit0=0 ignored", v, 0);

        // R2: free-running wrap on timer 1
        quiesce();
        wr(REG_RUN, 2);
        capture(1, prev);
        wrapped = 1'b0;
        for (int i = 0; i < 40; i++) begin
            int d;
            repeat (8) @(negedge bclk);
            capture(1, v);
            d = (v - prev) & 255;
            chk(d >= 1 && d <= 60, "R2 count advances", d, 30);
            if (v < prev) wrapped = 1'b1;
            prev = v;
        end
        chk(wrapped, "R2 counter wraps", wrapped, 1);

        // R3: periodic on timer 2
        quiesce();
        wr(tmr_addr(2, TOFF_MODE), 1);
        wr(tmr_addr(2, TOFF_MATCH + 0), 9);
        wr(tmr_addr(2, TOFF_MATCH + 1), 3);
        wr(REG_RUN, 4);
        mx = 0;
        for (int i = 0; i < 20; i++) begin
            repeat (3) @(negedge bclk);
            capture(2, v);
            chk(v <= 9, "R3 count bounded by match0", v, 9);
            if (v > mx) mx = v;
        end
        chk(mx >= 5, "R3 count reaches upper range", mx, 9);
        wr(tmr_addr(2, TOFF_STAT), 2);
        repeat (40) @(negedge bclk);
        rd(tmr_addr(2, TOFF_STAT), v);
        chk(v[1] == 1'b1, "R3 match recurs", v[1], 1);
        chk(v[2] == 1'b0, "R3 unreachable comparator stays clear", v[2], 0);

        // R1: stop all, restart from zero
        quiesce();
        wr(REG_RUN, 7);
        repeat (100) @(negedge bclk);
        wr(REG_RUN, 0);
        repeat (10) @(negedge bclk);
        for (int t = 0; t < NT; t++) begin
            capture(t, v); chk(v == 0, "R1 write 0 stops all", v, 0);
        end
        wr(REG_RUN, 1);
        capture(0, v); chk(v <= 15, "R1 restart from zero", v, 15);
        rd(REG_RUN, v); chk(v == 1, "R1 run readback", v, 1);

        // R8: clock select
        wr(REG_CLKSEL, 'h2D);
        rd(REG_CLKSEL, v); chk(v == 'h2D, "R8 select readback", v, 'h2D);
        chk(clk_sel == 'h2D, "R8 select output", int'(clk_sel), 'h2D);
        wr(REG_CLKSEL, 0);
        chk(clk_sel == 0, "R8 select cleared", int'(clk_sel), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule